// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the storage side of a receive frame DMA. Incoming frames arrive one byte per cycle on a valid/data/last stream. The block keeps a ring of two-word descriptors in its own registers. Word 0 of each descriptor carries a word-aligned buffer address plus two flag bits. Word 1 carries the status written back by hardware. For every byte the block takes the current descriptor, writes the byte into that descriptor's buffer through a byte-write port, and closes the descriptor when the frame ends or the buffer fills. Closing writes the status word and sets the ownership bit.

Software reads any descriptor through an index-addressed read port. It hands a descriptor back to hardware by pulsing a release strobe, which clears the ownership bit. When the block must take a descriptor that software still owns, it discards the frame, or the rest of it, and counts the event. The walk through the ring follows the wrap flag back to entry 0.

Top module: `rxdr_writer`

## Requirements
- R1: After reset every descriptor is free (word 0 bit 0 = 0). Word 0 bits 31:2 give BUF_BASE + i*BUF_BYTES for entry i. Word 0 bit 1 (wrap) is 1 only on entry NDESC-1. Word 1 is zero, and the overrun count is zero.
- R2: Each accepted byte shows up one cycle later as buf_we=1, with buf_data equal to the byte. buf_addr is the descriptor's buffer address plus the byte's offset inside that buffer. No other cycle asserts buf_we.
- R3: A frame that fits one buffer closes its descriptor in the cycle after its last byte. Word 0 bit 0 becomes 1 and the address and wrap bits are kept. Word 1 = length in bits 13:0, with bit 14 (start) and bit 15 (end) both set.
- R4: A frame longer than BUF_BYTES continues into the following descriptors. The first gets bit 14 only and length 0. Middle descriptors get 0. The final one gets bit 15 and the total frame length.
- R5: Each frame starts in the descriptor after the one that closed last. After a descriptor with the wrap bit, the next one is entry 0.
- R6: If the descriptor to be taken has word 0 bit 0 = 1, the rest of the frame is discarded. No buffer write and no descriptor change result from it. The overrun count rises by 1, saturating at its maximum.
- R7: sw_release=1 clears bit 0 of word 0 of descriptor sw_idx at the next edge and keeps the other bits. A released descriptor can be filled again.
- R8: Cycles with in_valid=0 change nothing.
- R9: sw_word0 and sw_word1 show descriptor sw_idx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on in_data |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Byte address of the write |
| buf_data | output | 8 | Byte to write |
| sw_idx | input | IDX_W | Descriptor selected for read or release |
| sw_release | input | 1 | Return descriptor sw_idx to hardware |
| sw_word0 | output | 32 | Word 0 of descriptor sw_idx |
| sw_word1 | output | 32 | Word 1 of descriptor sw_idx |
| overrun_count | output | CNT_W | Saturating count of discarded frames |

## Verification
The bench uses a small ring of four 8-byte buffers. It sends a short frame with idle gaps to separate gating from streaming. A frame that exactly fills one buffer shows whether a full buffer counts as the end of the frame. A 19-byte frame crosses three buffers and the wrap point, so start, middle and end status and the return to entry 0 are exercised together. Back-to-back frames against owned descriptors show the discard path and the saturation of the counter. A release followed by a refill, and a frame that meets an owned descriptor part way through, show ownership hand-back and truncation.

// File: rtl/rxdr_pkg.sv
package rxdr_pkg;
    localparam int LEN_W    = 14;
    localparam int USED_BIT = 0;
    localparam int WRAP_BIT = 1;
    localparam int SOF_BIT  = 14;
    localparam int EOF_BIT  = 15;

    function automatic logic [31:0] status_word(logic [LEN_W-1:0] len, logic sof, logic eof);
        return {16'h0000, eof, sof, len};
    endfunction
endpackage

// File: rtl/rxdr_ring_store.sv
module rxdr_ring_store #(
    parameter int          NDESC     = 32,
    parameter int          BUF_BYTES = 1536,
    parameter logic [31:0] BUF_BASE  = 32'h0,
    localparam int         IDX_W     = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_we,
    input  logic [IDX_W-1:0] hw_idx,
    input  logic [31:0]      hw_status,
    input  logic [IDX_W-1:0] cur_idx,
    output logic [31:0]      cur_word0,
    input  logic             sw_release,
    input  logic [IDX_W-1:0] sw_idx,
    output logic [31:0]      sw_word0,
    output logic [31:0]      sw_word1
);
    import rxdr_pkg::*;

    localparam logic [31:0] STRIDE = 32'(BUF_BYTES);

    typedef struct packed {
        logic [NDESC-1:0][31:0] w0;
        logic [NDESC-1:0][31:0] w1;
    } ring_t;

    ring_t ring_d, ring_q;

    function automatic logic [31:0] init_word0(int i);
        logic [31:0] a;
        a = BUF_BASE + STRIDE * 32'(i);
        a[WRAP_BIT] = (i == NDESC - 1);
        a[USED_BIT] = 1'b0;
        return a;
    endfunction

    always_comb begin
        ring_d = ring_q;
        if (sw_release) ring_d.w0[sw_idx][USED_BIT] = 1'b0;
        if (hw_we) begin
            ring_d.w0[hw_idx][USED_BIT] = 1'b1;
            ring_d.w1[hw_idx]           = hw_status;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NDESC; i++) begin
                ring_q.w0[i] <= init_word0(i);
                ring_q.w1[i] <= '0;
            end
        end else begin
            ring_q <= ring_d;
        end
    end

    assign cur_word0 = ring_q.w0[cur_idx];
    assign sw_word0  = ring_q.w0[sw_idx];
    assign sw_word1  = ring_q.w1[sw_idx];
endmodule

// File: rtl/rxdr_frame_ctl.sv
module rxdr_frame_ctl #(
    parameter int  BUF_BYTES = 1536,
    parameter int  CNT_W     = 8,
    parameter int  IDX_W     = 5,
    localparam int OFF_W     = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [31:0]      cur_word0,
    output logic [IDX_W-1:0] cur_idx,
    output logic             hw_we,
    output logic [31:0]      hw_status,
    output logic             buf_we,
    output logic [31:0]      buf_addr,
    output logic [7:0]       buf_data,
    output logic [CNT_W-1:0] overrun_count
);
    import rxdr_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
        logic             first;
        logic [LEN_W-1:0] tlen;
        logic             drop;
        logic [CNT_W-1:0] ovr;
        logic             bwe;
        logic [31:0]      baddr;
        logic [7:0]       bdata;
    } st_t;

    st_t s_d, s_q;
    logic claim_busy, slot_full;
    logic [LEN_W-1:0] tlen_inc;

    always_comb begin
        s_d        = s_q;
        s_d.bwe    = 1'b0;
        hw_we      = 1'b0;
        hw_status  = '0;
        claim_busy = (s_q.off == '0) && cur_word0[USED_BIT];
        slot_full  = (s_q.off == OFF_W'(BUF_BYTES - 1));
        tlen_inc   = s_q.tlen + 1'b1;
        if (in_valid) begin
            if (s_q.drop) begin
                if (in_last) s_d.drop = 1'b0;
            end else if (claim_busy) begin
                if (s_q.ovr != '1) s_d.ovr = s_q.ovr + 1'b1;
                s_d.drop  = !in_last;
                s_d.first = 1'b1;
                s_d.tlen  = '0;
            end else begin
                s_d.bwe   = 1'b1;
                s_d.baddr = {cur_word0[31:2], 2'b00} + 32'(s_q.off);
                s_d.bdata = in_data;
                s_d.off   = s_q.off + 1'b1;
                s_d.tlen  = tlen_inc;
                if (in_last || slot_full) begin
                    hw_we     = 1'b1;
                    hw_status = status_word(in_last ? tlen_inc : '0, s_q.first, in_last);
                    s_d.idx   = cur_word0[WRAP_BIT] ? '0 : s_q.idx + 1'b1;
                    s_d.off   = '0;
                    s_d.first = in_last;
                    if (in_last) s_d.tlen = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.first <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_idx       = s_q.idx;
    assign buf_we        = s_q.bwe;
    assign buf_addr      = s_q.baddr;
    assign buf_data      = s_q.bdata;
    assign overrun_count = s_q.ovr;
endmodule

// File: rtl/rxdr_writer.sv
module rxdr_writer #(
    parameter int          NDESC     = 32,
    parameter int          BUF_BYTES = 1536,
    parameter logic [31:0] BUF_BASE  = 32'h0,
    parameter int          CNT_W     = 8,
    localparam int         IDX_W     = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             buf_we,
    output logic [31:0]      buf_addr,
    output logic [7:0]       buf_data,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic             sw_release,
    output logic [31:0]      sw_word0,
    output logic [31:0]      sw_word1,
    output logic [CNT_W-1:0] overrun_count
);
    logic [IDX_W-1:0] cur_idx;
    logic [31:0]      cur_word0;
    logic             hw_we;
    logic [31:0]      hw_status;

    rxdr_frame_ctl #(
        .BUF_BYTES(BUF_BYTES),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_last      (in_last),
        .cur_word0    (cur_word0),
        .cur_idx      (cur_idx),
        .hw_we        (hw_we),
        .hw_status    (hw_status),
        .buf_we       (buf_we),
        .buf_addr     (buf_addr),
        .buf_data     (buf_data),
        .overrun_count(overrun_count)
    );

    rxdr_ring_store #(
        .NDESC    (NDESC),
        .BUF_BYTES(BUF_BYTES),
        .BUF_BASE (BUF_BASE)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_we     (hw_we),
        .hw_idx    (cur_idx),
        .hw_status (hw_status),
        .cur_idx   (cur_idx),
        .cur_word0 (cur_word0),
        .sw_release(sw_release),
        .sw_idx    (sw_idx),
        .sw_word0  (sw_word0),
        .sw_word1  (sw_word1)
    );
endmodule

// File: rtl/rxdr_writer_chk.sv
module rxdr_writer_chk #(
    parameter int CNT_W = 8,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             buf_we,
    input logic [CNT_W-1:0] overrun_count,
    input logic             hw_we,
    input logic             hw_eof,
    input logic [13:0]      hw_len,
    input logic [IDX_W-1:0] cur_idx
);
    a_r2_write_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(in_valid));

    a_r6_count_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (overrun_count >= $past(overrun_count)));

    a_r6_count_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((overrun_count == $past(overrun_count)) ||
                  (overrun_count == $past(overrun_count) + 1'b1)));

    a_r4_len_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && !hw_eof) |-> (hw_len == '0));

    a_r3_end_has_length: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && hw_eof) |-> (hw_len != '0));

    a_r5_idx_moves_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_we |=> $stable(cur_idx));
endmodule

bind rxdr_writer rxdr_writer_chk #(
    .CNT_W(CNT_W),
    .IDX_W(IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .buf_we       (buf_we),
    .overrun_count(overrun_count),
    .hw_we        (hw_we),
    .hw_eof       (hw_status[15]),
    .hw_len       (hw_status[13:0]),
    .cur_idx      (cur_idx)
);

// File: tb/test_rxdr_writer.sv
module test_rxdr_writer;
    localparam int          ND    = 4;
    localparam int          BB    = 8;
    localparam logic [31:0] BASE  = 32'h1000;
    localparam int          CW    = 2;
    localparam int          IW    = $clog2(ND);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          buf_we;
    logic [31:0]   buf_addr;
    logic [7:0]    buf_data;
    logic [IW-1:0] sw_idx = '0;
    logic          sw_release = 1'b0;
    logic [31:0]   sw_word0, sw_word1;
    logic [CW-1:0] overrun_count;

    int checks = 0;
    int errors = 0;
    int we_seen = 0;

    always #4 clk = ~clk;

    rxdr_writer #(.NDESC(ND), .BUF_BYTES(BB), .BUF_BASE(BASE), .CNT_W(CW)) i_rxdr_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .sw_idx(sw_idx),
        .sw_release(sw_release), .sw_word0(sw_word0), .sw_word1(sw_word1),
        .overrun_count(overrun_count));

    // behavioural reference
    int unsigned m_w0 [ND];
    int unsigned m_w1 [ND];
    int m_idx, m_off, m_first, m_tlen, m_drop, m_ovr;
    int e_we;
    int unsigned e_addr, e_data;

    task automatic model_reset();
        for (int i = 0; i < ND; i++) begin
            m_w0[i] = BASE + i * BB + ((i == ND - 1) ? 2 : 0);
            m_w1[i] = 0;
        end
        m_idx = 0; m_off = 0; m_first = 1; m_tlen = 0; m_drop = 0; m_ovr = 0;
        e_we = 0; e_addr = 0; e_data = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            int unsigned cur;
            int wb, wb_idx;
            int unsigned wb_stat;
            cur = m_w0[m_idx];
            e_we = 0; wb = 0; wb_idx = m_idx; wb_stat = 0;
            if (in_valid) begin
                if (m_drop != 0) begin
                    if (in_last) m_drop = 0;
                end else if (m_off == 0 && (cur & 1) != 0) begin
                    if (m_ovr < (1 << CW) - 1) m_ovr++;
                    m_drop = in_last ? 0 : 1;
                    m_first = 1; m_tlen = 0;
                end else begin
                    e_we = 1; e_addr = (cur & ~32'd3) + m_off; e_data = in_data;
                    m_off++; m_tlen++;
                    if (in_last || m_off == BB) begin
                        wb = 1;
                        wb_stat = (in_last ? m_tlen : 0) | (m_first << 14) | (int'(in_last) << 15);
                        m_idx = ((cur & 2) != 0) ? 0 : m_idx + 1;
                        m_off = 0;
                        m_first = in_last ? 1 : 0;
                        if (in_last) m_tlen = 0;
                    end
                end
            end
            if (sw_release) m_w0[sw_idx] = m_w0[sw_idx] & ~32'd1;
            if (wb != 0) begin
                m_w0[wb_idx] = m_w0[wb_idx] | 1;
                m_w1[wb_idx] = wb_stat;
            end
        end
    end

    task automatic check(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (buf_we) we_seen++;
            check("R2 buf_we", buf_we, e_we);
            if (e_we != 0) begin
                check("R2 buf_addr", buf_addr, e_addr);
                check("R2 buf_data", buf_data, e_data);
            end
            check("R6 overrun_count", overrun_count, m_ovr);
            check("R9 sw_word0", sw_word0, m_w0[sw_idx]);
            check("R9 sw_word1", sw_word1, m_w1[sw_idx]);
        end
    end

    task automatic send(int n, bit gaps);
        for (int b = 0; b < n; b++) begin
            if (gaps && b == 1) begin
                @(negedge clk);
                in_valid = 1'b0; in_data = 8'hEE; in_last = 1'b1; // R8: idle cycle
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(b * 7 + n);
            in_last  = (b == n - 1);
            sw_idx   = IW'(b);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic peek(int i, int unsigned e0, int unsigned e1, string req);
        @(negedge clk);
        sw_idx = IW'(i);
        #2;
        check(req, sw_word0, e0);
        check(req, sw_word1, e1);
    endtask

    task automatic give_back(int i);
        @(negedge clk);
        sw_idx = IW'(i); sw_release = 1'b1;
        @(negedge clk);
        sw_release = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset image
        peek(0, 32'h1000, 0, "R1 desc0");
        peek(1, 32'h1008, 0, "R1 desc1");
        peek(2, 32'h1010, 0, "R1 desc2");
        peek(3, 32'h101A, 0, "R1 desc3 wrap");
        check("R1 overrun", overrun_count, 0);
        // R3 + R8: short frame with idle gap
        send(3, 1'b1);
        peek(0, 32'h1001, 32'hC003, "R3 single buffer");
        // R3: frame exactly filling a buffer
        send(8, 1'b0);
        peek(1, 32'h1009, 32'hC008, "R3 full buffer");
        give_back(0);
        give_back(1);
        peek(0, 32'h1000, 32'hC003, "R7 release keeps address");
        // R4 + R5: three buffers across the wrap
        send(19, 1'b0);
        peek(2, 32'h1011, 32'h4000, "R4 first part");
        peek(3, 32'h101B, 32'h0000, "R4 middle part");
        peek(0, 32'h1001, 32'h8013, "R5 wrap to entry 0 end part");
        send(2, 1'b0);
        peek(1, 32'h1009, 32'hC002, "R5 next entry");
        // R6: ring full, frames dropped, counter saturates
        w = we_seen;
        for (int k = 0; k < 4; k++) send(3, 1'b0);
        check("R6 saturated count", overrun_count, 3);
        check("R6 no buffer writes", we_seen - w, 0);
        peek(2, 32'h1011, 32'h4000, "R6 descriptor untouched");
        // R7: refill after release
        give_back(2);
        send(1, 1'b0);
        peek(2, 32'h1011, 32'hC001, "R7 refilled");
        // R6: mid-frame truncation on an owned descriptor
        give_back(3);
        send(10, 1'b0);
        peek(3, 32'h101B, 32'h4000, "R6 truncated first part");
        peek(0, 32'h1001, 32'h8013, "R6 owned entry kept");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule